// File: doc/BRIEF.md
# Dual Control-Register Serial Slave

This block is a two-wire serial bus (I2C) target. It holds the control settings for a two-channel supply controller. It watches an oversampled clock line and data line, recognises START and STOP, and compares the 7-bit address against the fixed pattern `000100x`. The `x` bit comes from a strap pin. It answers with an acknowledge by pulling the data line low through an open-drain enable.

A write carries one data byte. Bit 7 of that byte chooses which register is written, and the bits below it carry the fields. A read returns both registers in turn. Each read-back byte carries the current overload and over-temperature inputs in its read-only positions.

Two protections sit in front of the registers. While power is not good, the block acknowledges nothing. While over-temperature is asserted, every writable field is held at zero.

Top module: `dual_reg_i2c_slave`

## Requirements
- R1: After reset both configuration outputs are zero and the data line is not driven.
- R2: An address byte whose upper seven bits equal `0001 00` followed by `addr_sel_i` is acknowledged: `sda_oe_o` is high during the ninth SCL high period. The last address bit is the direction, with 1 meaning read.
- R3: Any other address is not acknowledged, and the data byte that follows it changes no register.
- R4: A written data byte with bit 7 = 0 loads bits 6..1 into `cfg_a_o[5:0]`, in the same order. Bit 0 is ignored and `cfg_b_o` is left unchanged.
- R5: A written data byte with bit 7 = 1 loads bits 6..2 into `cfg_b_o[4:0]`. Bits 1..0 are ignored and `cfg_a_o` is left unchanged.
- R6: A read sends, MSB first, the first byte `{0, cfg_a_o, ovl_a_i}` and then the byte `{1, cfg_b_o, otemp_i, ovl_b_i}`. The flags are taken live when each byte starts, and the bytes keep alternating while the master acknowledges.
- R7: While `pwr_ok_i` is low at the end of an address or data byte, that byte is not acknowledged, and no register changes.
- R8: While `otemp_i` is high, both configuration outputs are zero, and writes made during that time are lost.
- R9: SCL or SDA pulses shorter than the filter length are ignored. The slave changes `sda_oe_o` only while the filtered SCL is low.
- R10: A STOP before a data byte is complete writes nothing. A START in the middle of a byte restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (wired level) |
| sda_oe_o | output | 1 | High pulls the data line low |
| addr_sel_i | input | 1 | Strap for the variable address bit |
| pwr_ok_i | input | 1 | Supply good; low suppresses acknowledge |
| otemp_i | input | 1 | Over-temperature flag |
| ovl_a_i | input | 1 | Channel A overload flag |
| ovl_b_i | input | 1 | Channel B overload flag |
| cfg_a_o | output | 6 | Channel A control fields |
| cfg_b_o | output | 5 | Channel B control fields |

## Verification
The bench writes bytes with the select bit in each state and checks that the other register stays put. A decoder that used the wrong select polarity, or ignored the select bit, would corrupt the neighbouring channel.

Several directed tests follow:
- A wrong address, and power dropping between the address byte and the data byte, must both leave the registers unchanged. A slave that checked power only at the address, or acknowledged regardless, would commit the write.
- A one-cycle SCL glitch inside a data byte must be ignored. Without the filter, the glitch would shift in an extra bit and store a shifted value.
- An aborted byte and a repeated START must not write anything.
- Reads taken with different flag inputs must show the live status. A design that latched the flags would return stale values.
- A write sent while over-temperature is asserted must not survive once the flag clears.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam int CFG_A_W = 6;
  localparam int CFG_B_W = 5;
  localparam logic [5:0] ADDR_FIXED = 6'b000100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_DACK, ST_RD, ST_MACK, ST_SKIP
  } bus_st_e;
endpackage

// File: rtl/dr_line_filter.sv
module dr_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   s;

  assign s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '1;
      cnt_q   <= '0;
      clean_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      if (s == clean_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        clean_o <= s;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // output only follows a level seen on consecutive samples
  AST_FILT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clean_o) |-> ($past(s) == clean_o && $past(s, 2) == clean_o)); // R9
endmodule

// File: rtl/dr_reg_bank.sv
module dr_reg_bank import dr_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [7:0]         wr_data_i,
  input  logic               otemp_i,
  input  logic               ovl_a_i,
  input  logic               ovl_b_i,
  output logic [CFG_A_W-1:0] cfg_a_o,
  output logic [CFG_B_W-1:0] cfg_b_o,
  output logic [7:0]         rd_a_o,
  output logic [7:0]         rd_b_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_a_o <= '0;
      cfg_b_o <= '0;
    end else if (otemp_i) begin
      cfg_a_o <= '0;
      cfg_b_o <= '0;
    end else if (wr_en_i) begin
      if (!wr_data_i[7]) cfg_a_o <= wr_data_i[6:1];
      else               cfg_b_o <= wr_data_i[6:2];
    end
  end

  assign rd_a_o = {1'b0, cfg_a_o, ovl_a_i};
  assign rd_b_o = {1'b1, cfg_b_o, otemp_i, ovl_b_i};

  AST_OT_WIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otemp_i |=> (cfg_a_o == '0 && cfg_b_o == '0)); // R8
  AST_SEL_A_KEEPS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !otemp_i && !wr_data_i[7]) |=> $stable(cfg_b_o)); // R4
  AST_SEL_B_KEEPS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !otemp_i && wr_data_i[7]) |=> $stable(cfg_a_o)); // R5
endmodule

// File: rtl/dr_i2c_engine.sv
module dr_i2c_engine import dr_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel_i,
  input  logic       pwr_ok_i,
  input  logic [7:0] rd_a_i,
  input  logic [7:0] rd_b_i,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  bus_st_e    st_q;
  logic       scl_q, sda_q;
  logic [2:0] cnt_q;
  logic [7:0] sh_q;
  logic       rw_q, flag_q, next_b_q;
  logic       start_c, stop_c, rise_c, fall_c, ack_drv;

  assign start_c = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_c  = scl_i & ~scl_q;
  assign fall_c  = ~scl_i & scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      cnt_q     <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      flag_q    <= 1'b0;
      next_b_q  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      scl_q   <= scl_i;
      sda_q   <= sda_i;
      wr_en_o <= 1'b0;
      if (start_c) begin
        st_q   <= ST_ADDR;
        cnt_q  <= '0;
        flag_q <= 1'b0;
      end else if (stop_c) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_WR: begin
            if (rise_c) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == 3'd7) flag_q <= 1'b1;
            end else if (fall_c && flag_q) begin
              flag_q <= 1'b0;
              if (!pwr_ok_i) begin
                st_q <= ST_SKIP;
              end else if (st_q == ST_ADDR) begin
                if (sh_q[7:1] == {ADDR_FIXED, addr_sel_i}) begin
                  rw_q <= sh_q[0];
                  st_q <= ST_AACK;
                end else begin
                  st_q <= ST_SKIP;
                end
              end else begin
                wr_en_o   <= 1'b1;
                wr_data_o <= sh_q;
                st_q      <= ST_DACK;
              end
            end
          end
          ST_AACK: if (fall_c) begin
            cnt_q <= '0;
            if (rw_q) begin
              sh_q     <= rd_a_i;
              next_b_q <= 1'b1;
              st_q     <= ST_RD;
            end else begin
              st_q <= ST_WR;
            end
          end
          ST_DACK: if (fall_c) begin
            cnt_q <= '0;
            st_q  <= ST_WR;
          end
          ST_RD: if (fall_c) begin
            if (cnt_q == 3'd7) begin
              st_q <= ST_MACK;
            end else begin
              sh_q  <= {sh_q[6:0], 1'b1};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_MACK: begin
            if (rise_c) flag_q <= ~sda_i;
            else if (fall_c) begin
              if (flag_q) begin
                sh_q     <= next_b_q ? rd_b_i : rd_a_i;
                next_b_q <= ~next_b_q;
                cnt_q    <= '0;
                st_q     <= ST_RD;
              end else begin
                st_q <= ST_SKIP;
              end
              flag_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ack_drv  = (st_q == ST_AACK) || (st_q == ST_DACK);
  assign sda_oe_o = ack_drv || (st_q == ST_RD && !sh_q[7]);

  AST_ACK_NEEDS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_drv) |-> $past(pwr_ok_i)); // R7
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i); // R9
  AST_WR_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (st_q == ST_DACK)); // R3
endmodule

// File: rtl/dual_reg_i2c_slave.sv
module dual_reg_i2c_slave import dr_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               addr_sel_i,
  input  logic               pwr_ok_i,
  input  logic               otemp_i,
  input  logic               ovl_a_i,
  input  logic               ovl_b_i,
  output logic [CFG_A_W-1:0] cfg_a_o,
  output logic [CFG_B_W-1:0] cfg_b_o
);
  logic [1:0] raw, clean;
  logic       wr_en;
  logic [7:0] wr_data, rd_a, rd_b;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    dr_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk_i, .rst_ni, .raw_i(raw[g]), .clean_o(clean[g])
    );
  end

  dr_i2c_engine u_eng (
    .clk_i, .rst_ni,
    .scl_i(clean[0]), .sda_i(clean[1]),
    .addr_sel_i, .pwr_ok_i,
    .rd_a_i(rd_a), .rd_b_i(rd_b),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .sda_oe_o
  );

  dr_reg_bank u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .otemp_i, .ovl_a_i, .ovl_b_i,
    .cfg_a_o, .cfg_b_o,
    .rd_a_o(rd_a), .rd_b_o(rd_b)
  );
endmodule

// File: tb/sim_dual_reg_i2c_slave.sv
`timescale 1ns/1ps
module sim_dual_reg_i2c_slave;
  localparam int Q = 10;
  localparam int NV = 6;
  // {addr_sel, data, expected cfg_a, expected cfg_b}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 8'h7E, 6'h3F, 5'h00},
    {1'b1, 8'hFF, 6'h3F, 5'h1F},
    {1'b0, 8'h2B, 6'h15, 5'h1F},
    {1'b1, 8'h83, 6'h15, 5'h00},
    {1'b1, 8'hD4, 6'h15, 5'h15},
    {1'b0, 8'h01, 6'h00, 5'h15}
  };

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_m = 1;
  logic addr_sel = 0, pwr_ok = 1, otemp = 0, ovl_a = 0, ovl_b = 0;
  logic sda_oe, sda_line;
  logic [5:0] cfg_a;
  logic [4:0] cfg_b;
  int n_chk = 0, n_fail = 0;

  assign sda_line = sda_m & ~sda_oe;
  always #2 clk = ~clk;

  dual_reg_i2c_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .pwr_ok_i(pwr_ok), .otemp_i(otemp),
    .ovl_a_i(ovl_a), .ovl_b_i(ovl_b), .cfg_a_o(cfg_a), .cfg_b_o(cfg_b)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1; tick(Q); scl = 1; tick(2*Q); sda_m = 0; tick(2*Q); scl = 0; tick(Q);
  endtask

  task automatic bus_stop;
    scl = 0; sda_m = 0; tick(Q); scl = 1; tick(2*Q); sda_m = 1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      tick(Q); sda_m = b[i];
      if (glitch && i == 4) begin scl = 1; tick(1); scl = 0; end
      tick(Q); scl = 1; tick(2*Q); scl = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    send_bits(b, 8, glitch);
    tick(Q); sda_m = 1; tick(Q); scl = 1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl = 0;
  endtask

  task automatic read_byte(input bit m_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; tick(2*Q); scl = 1; tick(Q); b[i] = sda_line; tick(Q); scl = 0;
    end
    tick(Q); sda_m = ~m_ack; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(1); sda_m = 1;
  endtask

  task automatic wr_xfer(input logic as, input logic [7:0] d, input bit glitch,
                         output bit a_ack, output bit d_ack);
    bus_start;
    send_byte({6'b000100, as, 1'b0}, 1'b0, a_ack);
    send_byte(d, glitch, d_ack);
    bus_stop;
    tick(20);
  endtask

  task automatic rd_xfer(input logic as, output bit a_ack, output logic [7:0] b0,
                         output logic [7:0] b1);
    bus_start;
    send_byte({6'b000100, as, 1'b1}, 1'b0, a_ack);
    read_byte(1'b1, b0);
    read_byte(1'b0, b1);
    bus_stop;
    tick(20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit a, d;
    logic [7:0] b0, b1;
    tick(5);
    check("R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1; tick(10);
    check("R1 cfg_a after reset", cfg_a, 0);
    check("R1 cfg_b after reset", cfg_b, 0);

    // vector walk: R2 R4 R5
    for (int v = 0; v < NV; v++) begin
      addr_sel = VEC[v][19];
      wr_xfer(VEC[v][19], VEC[v][18:11], 1'b0, a, d);
      check("R2 address ack", a, 1);
      check("R2 data ack", d, 1);
      check("R4 cfg_a", cfg_a, VEC[v][10:5]);
      check("R5 cfg_b", cfg_b, VEC[v][4:0]);
    end

    // R3 wrong address
    addr_sel = 0;
    wr_xfer(1'b1, 8'h7E, 1'b0, a, d);
    check("R3 no ack on mismatch", a, 0);
    check("R3 cfg_a kept", cfg_a, 6'h00);

    // R6 reads with live flags
    wr_xfer(1'b0, 8'h7E, 1'b0, a, d);
    ovl_a = 1; ovl_b = 1;
    rd_xfer(1'b0, a, b0, b1);
    check("R6 read addr ack", a, 1);
    check("R6 first byte", b0, 8'h7F);
    check("R6 second byte", b1, 8'hD5);
    ovl_a = 0; ovl_b = 0;
    rd_xfer(1'b0, a, b0, b1);
    check("R6 first byte live", b0, 8'h7E);
    check("R6 second byte live", b1, 8'hD4);

    // R7 power not good
    pwr_ok = 0;
    wr_xfer(1'b0, 8'h01, 1'b0, a, d);
    check("R7 addr nack", a, 0);
    check("R7 cfg_a kept", cfg_a, 6'h3F);
    pwr_ok = 1;
    bus_start;
    send_byte(8'h10, 1'b0, a);
    pwr_ok = 0;
    send_byte(8'h01, 1'b0, d);
    bus_stop; tick(20);
    pwr_ok = 1;
    check("R7 addr ack while good", a, 1);
    check("R7 data nack after drop", d, 0);
    check("R7 cfg_a kept after drop", cfg_a, 6'h3F);

    // R9 SCL glitch inside a data byte
    wr_xfer(1'b0, 8'h2A, 1'b1, a, d);
    check("R9 glitch ack", d, 1);
    check("R9 glitch data", cfg_a, 6'h15);

    // R10 stop mid-byte, then repeated start mid-byte
    bus_start;
    send_byte(8'h10, 1'b0, a);
    send_bits(8'h01, 4, 1'b0);
    bus_stop; tick(20);
    check("R10 stop mid-byte", cfg_a, 6'h15);
    bus_start;
    send_byte(8'h10, 1'b0, a);
    send_bits(8'h01, 4, 1'b0);
    bus_start;
    send_byte(8'h10, 1'b0, a);
    send_byte(8'h7E, 1'b0, d);
    bus_stop; tick(20);
    check("R10 repeated start ack", d, 1);
    check("R10 repeated start data", cfg_a, 6'h3F);

    // R8 over-temperature
    otemp = 1; tick(5);
    check("R8 cfg_a wiped", cfg_a, 0);
    check("R8 cfg_b wiped", cfg_b, 0);
    wr_xfer(1'b0, 8'h7E, 1'b0, a, d);
    check("R8 write lost", cfg_a, 0);
    rd_xfer(1'b0, a, b0, b1);
    check("R8 status byte", b1, 8'h82);
    otemp = 0; tick(5);
    check("R8 still zero after clear", cfg_a, 0);
    wr_xfer(1'b0, 8'h7E, 1'b0, a, d);
    check("R8 write after clear", cfg_a, 6'h3F);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule